// File: doc/BRIEF.md
# Framed CRC-32 Receive Checker

This block sits after the 8b/10b decoder on a receive link. It takes one decoded 32-bit word per clock, together with a flag that marks the most significant byte as a K character. It watches the stream for start-of-frame ordered sets. When it sees one, it runs a CRC-32 division over every following data word, including the CRC word the sender appended. When the frame is closed by an end-of-frame or by any other ordered set, it raises a one-cycle ready pulse. An OK flag rides on that pulse when the division left the expected remainder.

Checking can be turned off with an enable input. A raw-mode input bypasses the checker completely. An intra-frame idle mode lets a sender pause inside a frame with idle ordered sets without closing the check. Only the start, end and idle patterns are decoded. Every other K word is simply treated as a frame closer.

Top module: `rx_frame_crc_check`

## Requirements
- R1: While `check_en_i` is low, no frame is opened and `crc_ready_o` stays low. A frame that is open when the enable drops is discarded, so a later closing word yields no pulse.
- R2: A start-of-frame word is recognised only with all of these true:
  - `rx_kchar_i` is high.
  - Byte 3 (bits 31:24) is 0xBC.
  - Byte 2 is 0xB5.
  - Bytes 1 and 0 are equal and are one of 0x17, 0x37, 0x57, 0x35, 0x55, 0x36, 0x56, 0x58.
  
  Division begins with the word after it; the start word itself is excluded.
- R3: While a frame is open, any word with `rx_kchar_i` high closes the check. The exceptions are a start-of-frame word and a skipped idle. An end-of-frame word has 0xBC in byte 3, 0x95, 0xB5, 0x8A or 0xAA in byte 2, and equal bytes 1 and 0 from 0x75, 0x95, 0xF5, 0xD5.
- R4: `crc_ready_o` goes high in the clock cycle after the closing word is sampled, and stays high for exactly one cycle.
- R5: The CRC uses polynomial 0x04C11DB7 with an all-ones preset. Each word is fed bit 31 first. `crc_ok_o` is high with the ready pulse only if the register then equals 0xC704DD7B. That is the value left when the payload is followed by the bitwise complement of its own CRC.
- R6: An idle word has 0xBC in byte 3, 0x95 or 0xB5 in byte 2, and 0xB5 in bytes 1 and 0, with `rx_kchar_i` high. With `idle_skip_i` high, an idle inside an open frame leaves the CRC and the frame untouched. With `idle_skip_i` low, it closes the check like any other ordered set.
- R7: While `raw_mode_i` is high, the checker is bypassed. No pulse is produced, and an open frame is discarded.
- R8: A start-of-frame that arrives inside an open frame restarts the CRC from the preset without producing a ready pulse.
- R9: Reset (`rst_ni` low, asynchronous) clears both outputs at once and closes any open frame.
- R10: Data words and ordered sets that arrive while no frame is open produce no ready pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_word_i | input | 32 | Decoded receive word, byte 3 is most significant |
| rx_kchar_i | input | 1 | Byte 3 of the word is a K character |
| check_en_i | input | 1 | Enables frame CRC checking |
| idle_skip_i | input | 1 | Ignore idle ordered sets inside a frame |
| raw_mode_i | input | 1 | Raw data path selected; checker bypassed |
| crc_ready_o | output | 1 | One-cycle pulse: a check result is available |
| crc_ok_o | output | 1 | Remainder matched; valid with crc_ready_o |

## Verification
A lost or stuck frame-open bit shows up in the cycle after the next closing word. It appears as a missing or spurious `crc_ready_o`. A corrupted CRC register stays invisible until the frame closes. It then shows only as a wrong `crc_ok_o` on that single pulse. So the stimulus closes a frame after each scenario: restart, skipped idle, unskipped idle, wrong CRC word, and each of the three end-of-frame variants. This lets every disturbance of the internal state reach the ports within a cycle or two.

// File: rtl/rxcrc_pkg.sv
package rxcrc_pkg;

  localparam logic [7:0] K28_5    = 8'hBC;
  localparam logic [7:0] SOF_MID  = 8'hB5;
  localparam logic [7:0] IDLE_TAIL = 8'hB5;

  typedef struct packed {
    logic sof;
    logic eof;
    logic idle;
  } word_class_t;

  function automatic logic sof_tail(input logic [7:0] b);
    case (b)
      8'h17, 8'h37, 8'h57, 8'h35, 8'h55, 8'h36, 8'h56, 8'h58: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic eof_mid(input logic [7:0] b);
    case (b)
      8'h95, 8'hB5, 8'h8A, 8'hAA: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic eof_tail(input logic [7:0] b);
    case (b)
      8'h75, 8'h95, 8'hF5, 8'hD5: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rxcrc_classify.sv
module rxcrc_classify
  import rxcrc_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              kchar_i,
  output word_class_t       cls_o
);

  localparam int NBYTES = WORD_W / 8;

  logic [7:0] b3, b2, b1, b0;
  logic       lead, pair;

  assign b3 = word_i[8*NBYTES-1 -: 8];
  assign b2 = word_i[8*NBYTES-9 -: 8];
  assign b1 = word_i[15:8];
  assign b0 = word_i[7:0];

  assign lead = kchar_i && (b3 == K28_5);
  assign pair = (b1 == b0);

  always_comb begin
    cls_o.sof  = lead && (b2 == SOF_MID) && pair && sof_tail(b1);
    cls_o.eof  = lead && eof_mid(b2) && pair && eof_tail(b1);
    cls_o.idle = lead && ((b2 == 8'h95) || (b2 == 8'hB5)) && pair && (b1 == IDLE_TAIL);
  end

endmodule

// File: rtl/rxcrc_lfsr.sv
module rxcrc_lfsr #(
  parameter int          CRC_W = 32,
  parameter logic [31:0] POLY  = 32'h04C1_1DB7,
  parameter logic [31:0] SEED  = 32'hFFFF_FFFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [CRC_W-1:0] data_i,
  output logic [CRC_W-1:0] crc_o
);

  localparam logic [CRC_W-1:0] POLY_W = POLY[CRC_W-1:0];
  localparam logic [CRC_W-1:0] SEED_W = SEED[CRC_W-1:0];

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] chain [CRC_W+1];

  assign chain[0] = crc_q;

  // one stage per data bit, MSB first
  for (genvar i = 0; i < CRC_W; i++) begin : g_bit
    logic fb;
    assign fb = chain[i][CRC_W-1] ^ data_i[CRC_W-1-i];
    assign chain[i+1] = {chain[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY_W : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= SEED_W;
    else if (load_i)  crc_q <= SEED_W;
    else if (step_i)  crc_q <= chain[CRC_W];
  end

  assign crc_o = crc_q;

  assert_seed_on_sof_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (crc_q == SEED_W));

  assert_hold_when_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(crc_q));

endmodule

// File: rtl/rxcrc_frame_ctl.sv
module rxcrc_frame_ctl
  import rxcrc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        check_en_i,
  input  logic        raw_mode_i,
  input  logic        idle_skip_i,
  input  logic        kchar_i,
  input  word_class_t cls_i,
  input  logic        match_i,
  output logic        load_o,
  output logic        step_o,
  output logic        ready_o,
  output logic        ok_o
);

  logic active, open_q, open_d;
  logic sof_hit, skip_hit, close_hit, data_hit;

  assign active    = check_en_i && !raw_mode_i;
  assign sof_hit   = active && cls_i.sof;
  assign skip_hit  = active && open_q && cls_i.idle && idle_skip_i;
  assign close_hit = active && open_q && kchar_i && !cls_i.sof && !skip_hit;
  assign data_hit  = active && open_q && !kchar_i;

  assign load_o = sof_hit;
  assign step_o = data_hit;

  always_comb begin
    open_d = open_q;
    if (!active)        open_d = 1'b0;
    else if (sof_hit)   open_d = 1'b1;
    else if (close_hit) open_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q  <= 1'b0;
      ready_o <= 1'b0;
      ok_o    <= 1'b0;
    end else begin
      open_q  <= open_d;
      ready_o <= close_hit;
      ok_o    <= close_hit && match_i;
    end
  end

  assert_ready_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  assert_ok_with_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> ready_o);

  assert_disabled_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !check_en_i |=> (!ready_o && !open_q));

  assert_raw_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_mode_i |=> (!ready_o && !open_q));

  assert_restart_no_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_hit |=> (open_q && !ready_o));

  assert_idle_skip_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_hit |=> (open_q && !ready_o));

  assert_no_frame_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_q && !cls_i.sof) |=> !ready_o);

  assert_class_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cls_i.sof && (cls_i.eof || cls_i.idle)));

endmodule

// File: rtl/rx_frame_crc_check.sv
module rx_frame_crc_check
  import rxcrc_pkg::*;
#(
  parameter int          WORD_W  = 32,
  parameter logic [31:0] POLY    = 32'h04C1_1DB7,
  parameter logic [31:0] SEED    = 32'hFFFF_FFFF,
  parameter logic [31:0] RESIDUE = 32'hC704_DD7B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] rx_word_i,
  input  logic              rx_kchar_i,
  input  logic              check_en_i,
  input  logic              idle_skip_i,
  input  logic              raw_mode_i,
  output logic              crc_ready_o,
  output logic              crc_ok_o
);

  word_class_t       cls;
  logic              load, step, match;
  logic [WORD_W-1:0] crc;

  rxcrc_classify #(.WORD_W(WORD_W)) u_classify (
    .word_i  (rx_word_i),
    .kchar_i (rx_kchar_i),
    .cls_o   (cls)
  );

  rxcrc_lfsr #(.CRC_W(WORD_W), .POLY(POLY), .SEED(SEED)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .data_i (rx_word_i),
    .crc_o  (crc)
  );

  // residue compare replaces a final complement stage
  assign match = (crc == RESIDUE[WORD_W-1:0]);

  rxcrc_frame_ctl u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .check_en_i  (check_en_i),
    .raw_mode_i  (raw_mode_i),
    .idle_skip_i (idle_skip_i),
    .kchar_i     (rx_kchar_i),
    .cls_i       (cls),
    .match_i     (match),
    .load_o      (load),
    .step_o      (step),
    .ready_o     (crc_ready_o),
    .ok_o        (crc_ok_o)
  );

endmodule

// File: tb/rx_frame_crc_check_tb.sv
`timescale 1ns/1ps
module rx_frame_crc_check_tb;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] word = '0;
  logic        kchar = 1'b0, en = 1'b0, skip = 1'b0, raw = 1'b0;
  logic        rdy, ok;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  rx_frame_crc_check u_dut (
    .clk_i (clk), .rst_ni (rst_ni), .rx_word_i (word), .rx_kchar_i (kchar),
    .check_en_i (en), .idle_skip_i (skip), .raw_mode_i (raw),
    .crc_ready_o (rdy), .crc_ok_o (ok)
  );

  // R5 definition: MSB-first, poly 0x04C11DB7
  function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [31:0] w);
    logic [31:0] c;
    c = c_in;
    for (int b = 31; b >= 0; b--) begin
      logic fb;
      fb = c[31] ^ w[b];
      c = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C1_1DB7;
    end
    return c;
  endfunction

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", what, act, exp);
    end
  endtask

  task automatic put(input logic e, input logic s, input logic r, input logic k, input logic [31:0] w);
    @(negedge clk);
    en = e; skip = s; raw = r; kchar = k; word = w;
    @(posedge clk);
    #1;
  endtask

  // {en,skip,raw,k,op[1:0],word[31:0],exp_rdy,exp_ok}
  // op: 0 plain, 1 preset bench CRC, 2 accumulate, 3 replace by complemented CRC
  localparam int NV = 28;
  localparam logic [39:0] VEC [NV] = '{
    {4'b1000, 2'd0, 32'h1234_5678, 2'b00},  // R10 data, no frame
    {4'b1001, 2'd0, 32'hBC95_7575, 2'b00},  // R10 EOF, no frame
    {4'b1001, 2'd1, 32'hBCB5_1717, 2'b00},  // R2 SOF
    {4'b1000, 2'd2, 32'h1111_1111, 2'b00},
    {4'b1000, 2'd2, 32'hA5A5_A5A5, 2'b00},
    {4'b1000, 2'd3, 32'h0000_0000, 2'b00},
    {4'b1001, 2'd0, 32'hBCB5_7575, 2'b11},  // R3 R5 good frame
    {4'b1000, 2'd0, 32'hDEAD_BEEF, 2'b00},  // R4 pulse gone
    {4'b1001, 2'd1, 32'hBCB5_3535, 2'b00},
    {4'b1000, 2'd2, 32'h0102_0304, 2'b00},
    {4'b1000, 2'd0, 32'hCAFE_F00D, 2'b00},  // wrong CRC word
    {4'b1001, 2'd0, 32'hBC8A_9595, 2'b10},  // R5 bad frame
    {4'b1001, 2'd1, 32'hBCB5_5858, 2'b00},
    {4'b1000, 2'd2, 32'h0F0F_0F0F, 2'b00},
    {4'b1101, 2'd0, 32'hBC95_B5B5, 2'b00},  // R6 idle skipped
    {4'b1100, 2'd2, 32'h7654_3210, 2'b00},
    {4'b1101, 2'd0, 32'hBCB5_B5B5, 2'b00},  // R6 other idle skipped
    {4'b1100, 2'd3, 32'h0000_0000, 2'b00},
    {4'b1101, 2'd0, 32'hBC95_4A4A, 2'b11},  // R3 other ordered set closes
    {4'b1001, 2'd1, 32'hBCB5_3636, 2'b00},
    {4'b1000, 2'd2, 32'h9999_9999, 2'b00},
    {4'b1001, 2'd1, 32'hBCB5_5656, 2'b00},  // R8 restart
    {4'b1000, 2'd2, 32'h1357_9BDF, 2'b00},
    {4'b1000, 2'd3, 32'h0000_0000, 2'b00},
    {4'b1001, 2'd0, 32'hBCAA_D5D5, 2'b11},  // R8 only restarted CRC passes
    {4'b1001, 2'd1, 32'hBCB5_3737, 2'b00},
    {4'b1000, 2'd2, 32'h2468_2468, 2'b00},
    {4'b1001, 2'd0, 32'hBC95_B5B5, 2'b10}   // R6 idle closes when not skipped
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] bcrc;
    logic [31:0] w;
    bcrc = '1;
    repeat (3) @(posedge clk);
    #1;
    chk(rdy, 1'b0, "R9 reset ready");
    chk(ok, 1'b0, "R9 reset ok");
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      w = VEC[i][33:2];
      case (VEC[i][35:34])
        2'd1: bcrc = '1;
        2'd2: bcrc = crc_step(bcrc, w);
        2'd3: begin w = ~bcrc; bcrc = crc_step(bcrc, w); end
        default: ;
      endcase
      put(VEC[i][39], VEC[i][38], VEC[i][37], VEC[i][36], w);
      checks++;
      if (rdy !== VEC[i][1] || ok !== VEC[i][0]) begin
        errors++;
        $display("FAIL vec %0d (R2 R3 R4 R5 R6 R8 R10): ready/ok got %0b%0b expected %0b%0b",
                 i, rdy, ok, VEC[i][1], VEC[i][0]);
      end
    end

    // R1: disabled checker opens nothing
    put(1'b0, 1'b0, 1'b0, 1'b1, 32'hBCB5_1717);
    chk(rdy, 1'b0, "R1 SOF while disabled");
    put(1'b0, 1'b0, 1'b0, 1'b0, 32'h5555_AAAA);
    put(1'b0, 1'b0, 1'b0, 1'b1, 32'hBC95_7575);
    chk(rdy, 1'b0, "R1 EOF while disabled");
    put(1'b1, 1'b0, 1'b0, 1'b1, 32'hBC95_7575);
    chk(rdy, 1'b0, "R1 no frame after disabled SOF");
    // R1: drop enable mid-frame
    put(1'b1, 1'b0, 1'b0, 1'b1, 32'hBCB5_1717);
    put(1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0001);
    put(1'b1, 1'b0, 1'b0, 1'b1, 32'hBC95_7575);
    chk(rdy, 1'b0, "R1 frame discarded by enable drop");

    // R7: raw mode
    put(1'b1, 1'b0, 1'b0, 1'b1, 32'hBCB5_5555);
    put(1'b1, 1'b0, 1'b0, 1'b0, 32'h0BAD_F00D);
    put(1'b1, 1'b0, 1'b1, 1'b1, 32'hBC95_7575);
    chk(rdy, 1'b0, "R7 EOF in raw mode");
    put(1'b1, 1'b0, 1'b0, 1'b1, 32'hBC95_7575);
    chk(rdy, 1'b0, "R7 frame discarded by raw mode");

    // R9: reset clears a live pulse and an open frame
    put(1'b1, 1'b0, 1'b0, 1'b1, 32'hBCB5_1717);
    put(1'b1, 1'b0, 1'b0, 1'b1, 32'hBC95_7575);
    chk(rdy, 1'b1, "R9 pulse before reset");
    rst_ni = 1'b0;
    #1;
    chk(rdy, 1'b0, "R9 async clear ready");
    chk(ok, 1'b0, "R9 async clear ok");
    @(negedge clk);
    rst_ni = 1'b1;
    put(1'b1, 1'b0, 1'b0, 1'b1, 32'hBCB5_1717);
    put(1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_0002);
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    put(1'b1, 1'b0, 1'b0, 1'b1, 32'hBC95_7575);
    chk(rdy, 1'b0, "R9 frame closed by reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule